// File: doc/BRIEF.md
# Cache-Side Coherence Agent

This block keeps the coherence state of every line of a private cache that is kept coherent by a directory. Each line is in one of four conditions: absent, shared-clean, exclusive-modified, or waiting on a reply. For every processor access, the agent decides whether the line already satisfies it. On a miss it sends a shared-read or exclusive request toward the directory and parks the line in the waiting condition. When the matching reply arrives, it installs the line and signals the fill back to the processor.

In the other direction, the agent services invalidations and recalls from the directory. Each one produces an acknowledgement, and that acknowledgement carries a dirty-data flag whenever the line was held modified. The agent relies on the directory delivering messages reliably and in order. Data storage, replacement and the network itself sit outside the block. The agent only emits the request and response events with the line index, and the data array moves the payload.

Each line is recorded as a valid bit, a dirty (owner) bit and a waiting bit. Absent is all clear. Shared is valid only. Exclusive is valid and dirty. Waiting is the waiting bit alone.

Top module: `coh_agent`

## Requirements
- R1: After reset every line is absent, all output pulses are low, and `cpu_ready` is high.
- R2: An accepted load to an absent line gives `cpu_miss` and a request with `req_excl`=0 on the cycle after acceptance. The line then becomes waiting.
- R3: An accepted store to an absent or shared line gives `cpu_miss` and a request with `req_excl`=1 on the cycle after acceptance. The line then becomes waiting.
- R4: A load to a shared or exclusive line, and a store to an exclusive line, give `cpu_hit` on the cycle after acceptance. No request is sent and the state is unchanged.
- R5: `cpu_ready` is low while the line at `cpu_idx` is waiting, so accesses to it are stalled. Other lines stay ready.
- R6: Directory kind 0 (shared fill) installs a waiting line as shared, and kind 1 (exclusive fill) installs it as exclusive with the store done. Both pulse `cpu_fill` with the index one cycle later. A fill to a line that is not waiting is ignored.
- R7: Kind 2 (invalidate) always returns `rsp_valid` one cycle later and leaves a valid line absent. `rsp_data` is 1 only if the line was exclusive. A waiting line stays waiting.
- R8: Kind 3 (recall to shared) and kind 4 (recall to absent) always respond. An exclusive line returns `rsp_data`=1 and moves to shared or absent respectively. A shared line responds with `rsp_data`=0, and kind 4 makes it absent.
- R9: A directory message takes precedence over a processor access to the same line in the same cycle: `cpu_ready` is low for it. Messages and accesses to different lines proceed together.
- R10: Directory kinds 5 to 7 produce no response, no fill and no state change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_valid | input | 1 | Processor access present |
| cpu_store | input | 1 | 1 = store, 0 = load |
| cpu_idx | input | IDX_W | Line addressed by the access |
| cpu_ready | output | 1 | Access can be accepted this cycle |
| cpu_hit | output | 1 | Previous accepted access hit |
| cpu_miss | output | 1 | Previous accepted access missed |
| cpu_fill | output | 1 | A waiting line was just installed |
| cpu_fill_idx | output | IDX_W | Line installed by the fill |
| req_valid | output | 1 | Request to the directory |
| req_excl | output | 1 | 1 = exclusive request, 0 = shared read |
| req_idx | output | IDX_W | Line of the request |
| dir_valid | input | 1 | Directory message present |
| dir_kind | input | 3 | Message kind (0..4 defined) |
| dir_idx | input | IDX_W | Line addressed by the message |
| rsp_valid | output | 1 | Acknowledgement to the directory |
| rsp_data | output | 1 | Acknowledgement carries dirty data |
| rsp_idx | output | IDX_W | Line of the acknowledgement |

## Verification
Every result is registered once. Hits, misses and requests appear exactly one cycle after the edge that accepts the access. Fills and acknowledgements appear one cycle after the edge that takes the directory message, and the new line state governs the next access. Each scenario task drives its inputs on a falling edge and samples the outputs on the following falling edge, which is the only cycle in which the pulses are valid. Line state is never read directly. It is inferred from whether a later load or store hits or misses.

// File: rtl/coh_agent_pkg.sv
package coh_agent_pkg;

   typedef enum logic [2:0] {
      DM_FILL_SH     = 3'd0,
      DM_FILL_EX     = 3'd1,
      DM_INV         = 3'd2,
      DM_RECALL_SH   = 3'd3,
      DM_RECALL_NONE = 3'd4
   } dir_kind_e;

   typedef struct packed {
      logic pend;
      logic valid;
      logic dirty;
   } line_st_t;

   localparam line_st_t ST_ABSENT  = '{pend: 1'b0, valid: 1'b0, dirty: 1'b0};
   localparam line_st_t ST_SHARED  = '{pend: 1'b0, valid: 1'b1, dirty: 1'b0};
   localparam line_st_t ST_EXCL    = '{pend: 1'b0, valid: 1'b1, dirty: 1'b1};
   localparam line_st_t ST_WAITING = '{pend: 1'b1, valid: 1'b0, dirty: 1'b0};

endpackage

// File: rtl/coh_line_table.sv
module coh_line_table
   import coh_agent_pkg::*;
#(
   parameter int LINES = 8,
   parameter int IDX_W = $clog2(LINES)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cpu_we,
   input  logic [IDX_W-1:0] cpu_widx,
   input  line_st_t         cpu_wst,
   input  logic             dir_we,
   input  logic [IDX_W-1:0] dir_widx,
   input  line_st_t         dir_wst,
   output logic [LINES-1:0] pend_vec,
   output logic [LINES-1:0] valid_vec,
   output logic [LINES-1:0] dirty_vec
);

   for (genvar i = 0; i < LINES; i++) begin : g_entry
      line_st_t st_q;
      logic     hit_cpu;
      logic     hit_dir;

      assign hit_cpu = cpu_we && (cpu_widx == IDX_W'(i));
      assign hit_dir = dir_we && (dir_widx == IDX_W'(i));

      always_ff @(posedge clk) begin
         if (!rst_n)       st_q <= ST_ABSENT;
         else if (hit_dir) st_q <= dir_wst;
         else if (hit_cpu) st_q <= cpu_wst;
      end

      assign pend_vec[i]  = st_q.pend;
      assign valid_vec[i] = st_q.valid;
      assign dirty_vec[i] = st_q.dirty;
   end

   // R9
   wr_collide_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(cpu_we && dir_we && (cpu_widx == dir_widx)));

endmodule

// File: rtl/coh_cpu_ctl.sv
module coh_cpu_ctl
   import coh_agent_pkg::*;
#(
   parameter int IDX_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cpu_valid,
   input  logic             cpu_store,
   input  logic [IDX_W-1:0] cpu_idx,
   input  line_st_t         cur,
   input  logic             dir_valid,
   input  logic [IDX_W-1:0] dir_idx,
   output logic             cpu_ready,
   output logic             we,
   output logic [IDX_W-1:0] widx,
   output line_st_t         wst,
   output logic             cpu_hit,
   output logic             cpu_miss,
   output logic             req_valid,
   output logic             req_excl,
   output logic [IDX_W-1:0] req_idx
);

   logic clash;
   logic accept;
   logic satisfied;

   always_comb begin
      clash     = dir_valid && (dir_idx == cpu_idx);
      cpu_ready = !cur.pend && !clash;
      accept    = cpu_valid && cpu_ready;
      satisfied = cpu_store ? cur.dirty : cur.valid;
      we        = accept && !satisfied;
      widx      = cpu_idx;
      wst       = ST_WAITING;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cpu_hit   <= 1'b0;
         cpu_miss  <= 1'b0;
         req_valid <= 1'b0;
         req_excl  <= 1'b0;
         req_idx   <= '0;
      end else begin
         cpu_hit   <= accept && satisfied;
         cpu_miss  <= accept && !satisfied;
         req_valid <= accept && !satisfied;
         req_excl  <= cpu_store;
         req_idx   <= cpu_idx;
      end
   end

   // R5
   ready_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && (cpu_idx == req_idx)) |-> !cpu_ready);

endmodule

// File: rtl/coh_dir_ctl.sv
module coh_dir_ctl
   import coh_agent_pkg::*;
#(
   parameter int IDX_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             dir_valid,
   input  logic [2:0]       dir_kind,
   input  logic [IDX_W-1:0] dir_idx,
   input  line_st_t         cur,
   output logic             we,
   output logic [IDX_W-1:0] widx,
   output line_st_t         wst,
   output logic             cpu_fill,
   output logic [IDX_W-1:0] cpu_fill_idx,
   output logic             rsp_valid,
   output logic             rsp_data,
   output logic [IDX_W-1:0] rsp_idx
);

   logic fill_d;
   logic ack_d;
   logic wb_d;

   always_comb begin
      we     = 1'b0;
      wst    = ST_ABSENT;
      fill_d = 1'b0;
      ack_d  = 1'b0;
      wb_d   = 1'b0;
      widx   = dir_idx;
      if (dir_valid) begin
         case (dir_kind)
            DM_FILL_SH: begin
               fill_d = cur.pend;
               we     = cur.pend;
               wst    = ST_SHARED;
            end
            DM_FILL_EX: begin
               fill_d = cur.pend;
               we     = cur.pend;
               wst    = ST_EXCL;
            end
            DM_INV: begin
               ack_d = 1'b1;
               wb_d  = cur.dirty;
               we    = cur.valid;
               wst   = ST_ABSENT;
            end
            DM_RECALL_SH: begin
               ack_d = 1'b1;
               wb_d  = cur.dirty;
               we    = cur.dirty;
               wst   = ST_SHARED;
            end
            DM_RECALL_NONE: begin
               ack_d = 1'b1;
               wb_d  = cur.dirty;
               we    = cur.valid;
               wst   = ST_ABSENT;
            end
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cpu_fill     <= 1'b0;
         cpu_fill_idx <= '0;
         rsp_valid    <= 1'b0;
         rsp_data     <= 1'b0;
         rsp_idx      <= '0;
      end else begin
         cpu_fill     <= fill_d;
         cpu_fill_idx <= dir_idx;
         rsp_valid    <= ack_d;
         rsp_data     <= wb_d;
         rsp_idx      <= dir_idx;
      end
   end

   // R7
   rsp_data_qual_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_data |-> rsp_valid);

endmodule

// File: rtl/coh_agent.sv
module coh_agent
   import coh_agent_pkg::*;
#(
   parameter int LINES = 8,
   localparam int IDX_W = $clog2(LINES)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cpu_valid,
   input  logic             cpu_store,
   input  logic [IDX_W-1:0] cpu_idx,
   output logic             cpu_ready,
   output logic             cpu_hit,
   output logic             cpu_miss,
   output logic             cpu_fill,
   output logic [IDX_W-1:0] cpu_fill_idx,
   output logic             req_valid,
   output logic             req_excl,
   output logic [IDX_W-1:0] req_idx,
   input  logic             dir_valid,
   input  logic [2:0]       dir_kind,
   input  logic [IDX_W-1:0] dir_idx,
   output logic             rsp_valid,
   output logic             rsp_data,
   output logic [IDX_W-1:0] rsp_idx
);

   if (LINES < 2 || (LINES & (LINES - 1)) != 0) begin : g_bad_lines
      $error("coh_agent: LINES must be a power of two of at least 2");
   end

   logic [LINES-1:0] pend_vec;
   logic [LINES-1:0] valid_vec;
   logic [LINES-1:0] dirty_vec;
   line_st_t         cpu_cur;
   line_st_t         dir_cur;
   logic             cpu_we;
   logic [IDX_W-1:0] cpu_widx;
   line_st_t         cpu_wst;
   logic             dir_we;
   logic [IDX_W-1:0] dir_widx;
   line_st_t         dir_wst;

   assign cpu_cur = '{pend: pend_vec[cpu_idx], valid: valid_vec[cpu_idx],
                      dirty: dirty_vec[cpu_idx]};
   assign dir_cur = '{pend: pend_vec[dir_idx], valid: valid_vec[dir_idx],
                      dirty: dirty_vec[dir_idx]};

   coh_line_table #(.LINES(LINES), .IDX_W(IDX_W)) u_table (
      .clk       (clk),
      .rst_n     (rst_n),
      .cpu_we    (cpu_we),
      .cpu_widx  (cpu_widx),
      .cpu_wst   (cpu_wst),
      .dir_we    (dir_we),
      .dir_widx  (dir_widx),
      .dir_wst   (dir_wst),
      .pend_vec  (pend_vec),
      .valid_vec (valid_vec),
      .dirty_vec (dirty_vec)
   );

   coh_cpu_ctl #(.IDX_W(IDX_W)) u_cpu (
      .clk       (clk),
      .rst_n     (rst_n),
      .cpu_valid (cpu_valid),
      .cpu_store (cpu_store),
      .cpu_idx   (cpu_idx),
      .cur       (cpu_cur),
      .dir_valid (dir_valid),
      .dir_idx   (dir_idx),
      .cpu_ready (cpu_ready),
      .we        (cpu_we),
      .widx      (cpu_widx),
      .wst       (cpu_wst),
      .cpu_hit   (cpu_hit),
      .cpu_miss  (cpu_miss),
      .req_valid (req_valid),
      .req_excl  (req_excl),
      .req_idx   (req_idx)
   );

   coh_dir_ctl #(.IDX_W(IDX_W)) u_dir (
      .clk          (clk),
      .rst_n        (rst_n),
      .dir_valid    (dir_valid),
      .dir_kind     (dir_kind),
      .dir_idx      (dir_idx),
      .cur          (dir_cur),
      .we           (dir_we),
      .widx         (dir_widx),
      .wst          (dir_wst),
      .cpu_fill     (cpu_fill),
      .cpu_fill_idx (cpu_fill_idx),
      .rsp_valid    (rsp_valid),
      .rsp_data     (rsp_data),
      .rsp_idx      (rsp_idx)
   );

   // R2
   req_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |-> pend_vec[req_idx]);

   // R6
   fill_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_fill |-> (!pend_vec[cpu_fill_idx] && valid_vec[cpu_fill_idx]));

   // R8
   wb_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_data) |-> !dirty_vec[rsp_idx]);

endmodule

// File: tb/coh_agent_tb.sv
module coh_agent_tb;

   localparam int LINES = 8;
   localparam int IDX_W = $clog2(LINES);

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             cpu_valid = 1'b0;
   logic             cpu_store = 1'b0;
   logic [IDX_W-1:0] cpu_idx = '0;
   logic             cpu_ready;
   logic             cpu_hit;
   logic             cpu_miss;
   logic             cpu_fill;
   logic [IDX_W-1:0] cpu_fill_idx;
   logic             req_valid;
   logic             req_excl;
   logic [IDX_W-1:0] req_idx;
   logic             dir_valid = 1'b0;
   logic [2:0]       dir_kind = '0;
   logic [IDX_W-1:0] dir_idx = '0;
   logic             rsp_valid;
   logic             rsp_data;
   logic [IDX_W-1:0] rsp_idx;

   int n_chk = 0;
   int n_bad = 0;
   bit finished = 1'b0;

   always #5 clk = ~clk;

   coh_agent #(.LINES(LINES)) u_dut (
      .clk(clk), .rst_n(rst_n),
      .cpu_valid(cpu_valid), .cpu_store(cpu_store), .cpu_idx(cpu_idx),
      .cpu_ready(cpu_ready), .cpu_hit(cpu_hit), .cpu_miss(cpu_miss),
      .cpu_fill(cpu_fill), .cpu_fill_idx(cpu_fill_idx),
      .req_valid(req_valid), .req_excl(req_excl), .req_idx(req_idx),
      .dir_valid(dir_valid), .dir_kind(dir_kind), .dir_idx(dir_idx),
      .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_idx(rsp_idx)
   );

   task automatic chk(input int act, input int exp, input string tag);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   // One processor access; outputs sampled one cycle after acceptance.
   task automatic cpu_op(input bit st, input int idx, input bit exp_hit,
                         input string tag);
      cpu_valid = 1'b1; cpu_store = st; cpu_idx = IDX_W'(idx);
      @(negedge clk);
      chk(cpu_hit, exp_hit, {tag, " hit"});
      chk(cpu_miss, !exp_hit, {tag, " miss"});
      chk(req_valid, !exp_hit, {tag, " req_valid"});
      if (!exp_hit) begin
         chk(req_excl, st, {tag, " req_excl"});
         chk(req_idx, idx, {tag, " req_idx"});
      end
      cpu_valid = 1'b0;
   endtask

   // One directory message; outputs sampled one cycle later.
   task automatic dir_op(input int kind, input int idx, input bit exp_fill,
                         input bit exp_rsp, input bit exp_data, input string tag);
      dir_valid = 1'b1; dir_kind = 3'(kind); dir_idx = IDX_W'(idx);
      @(negedge clk);
      chk(cpu_fill, exp_fill, {tag, " fill"});
      if (exp_fill) chk(cpu_fill_idx, idx, {tag, " fill_idx"});
      chk(rsp_valid, exp_rsp, {tag, " rsp_valid"});
      if (exp_rsp) begin
         chk(rsp_data, exp_data, {tag, " rsp_data"});
         chk(rsp_idx, idx, {tag, " rsp_idx"});
      end
      chk(req_valid, 0, {tag, " no req"});
      dir_valid = 1'b0;
   endtask

   task automatic make_sh(input int idx);
      cpu_op(1'b0, idx, 1'b0, "R2 setup load");
      dir_op(0, idx, 1'b1, 1'b0, 1'b0, "R6 setup fill sh");
   endtask

   task automatic make_ex(input int idx);
      cpu_op(1'b1, idx, 1'b0, "R3 setup store");
      dir_op(1, idx, 1'b1, 1'b0, 1'b0, "R6 setup fill ex");
   endtask

   task automatic t_reset();
      chk(cpu_hit, 0, "R1 hit");
      chk(cpu_miss, 0, "R1 miss");
      chk(req_valid, 0, "R1 req");
      chk(rsp_valid, 0, "R1 rsp");
      chk(cpu_fill, 0, "R1 fill");
      chk(cpu_ready, 1, "R1 ready");
   endtask

   task automatic t_load_path();
      cpu_op(1'b0, 1, 1'b0, "R2 load absent");
      cpu_idx = 3'd1;
      #1 chk(cpu_ready, 0, "R5 waiting line stalls");
      cpu_idx = 3'd2;
      #1 chk(cpu_ready, 1, "R5 other line ready");
      dir_op(0, 1, 1'b1, 1'b0, 1'b0, "R6 fill shared");
      cpu_op(1'b0, 1, 1'b1, "R4 load shared hit");
   endtask

   task automatic t_store_path();
      cpu_op(1'b1, 1, 1'b0, "R3 store shared");
      dir_op(1, 1, 1'b1, 1'b0, 1'b0, "R6 fill excl");
      cpu_op(1'b1, 1, 1'b1, "R4 store excl hit");
      cpu_op(1'b0, 1, 1'b1, "R4 load excl hit");
      cpu_op(1'b1, 3, 1'b0, "R3 store absent");
      dir_op(1, 3, 1'b1, 1'b0, 1'b0, "R6 fill excl absent-line");
      cpu_op(1'b1, 3, 1'b1, "R4 store hit after fill");
   endtask

   task automatic t_recall();
      dir_op(3, 1, 1'b0, 1'b1, 1'b1, "R8 recall-sh excl");
      cpu_op(1'b0, 1, 1'b1, "R8 now shared load hit");
      cpu_op(1'b1, 1, 1'b0, "R8 now shared store miss");
      dir_op(1, 1, 1'b1, 1'b0, 1'b0, "R8 refill excl");
      dir_op(4, 1, 1'b0, 1'b1, 1'b1, "R8 recall-none excl");
      cpu_op(1'b0, 1, 1'b0, "R8 now absent load miss");
      dir_op(0, 1, 1'b1, 1'b0, 1'b0, "R8 refill sh");
      dir_op(3, 1, 1'b0, 1'b1, 1'b0, "R8 recall-sh shared");
      cpu_op(1'b0, 1, 1'b1, "R8 shared kept");
      dir_op(4, 1, 1'b0, 1'b1, 1'b0, "R8 recall-none shared");
      cpu_op(1'b0, 1, 1'b0, "R8 shared dropped");
      dir_op(0, 1, 1'b1, 1'b0, 1'b0, "R8 refill sh 2");
   endtask

   task automatic t_invalidate();
      dir_op(2, 1, 1'b0, 1'b1, 1'b0, "R7 inv shared");
      cpu_op(1'b0, 1, 1'b0, "R7 inv left absent");
      dir_op(0, 1, 1'b1, 1'b0, 1'b0, "R7 refill");
      dir_op(2, 5, 1'b0, 1'b1, 1'b0, "R7 inv absent acks");
      cpu_op(1'b0, 6, 1'b0, "R7 make waiting");
      dir_op(2, 6, 1'b0, 1'b1, 1'b0, "R7 inv waiting acks");
      cpu_idx = 3'd6;
      #1 chk(cpu_ready, 0, "R7 waiting kept");
      dir_op(0, 6, 1'b1, 1'b0, 1'b0, "R7 fill after inv");
      make_ex(2);
      dir_op(2, 2, 1'b0, 1'b1, 1'b1, "R7 inv excl writes back");
      cpu_op(1'b0, 2, 1'b0, "R7 excl now absent");
      dir_op(0, 2, 1'b1, 1'b0, 1'b0, "R7 refill 2");
   endtask

   task automatic t_stale_and_unknown();
      dir_op(0, 7, 1'b0, 1'b0, 1'b0, "R6 fill to absent ignored");
      cpu_op(1'b0, 7, 1'b0, "R6 still absent");
      dir_op(0, 7, 1'b1, 1'b0, 1'b0, "R6 fill ok");
      dir_op(1, 7, 1'b0, 1'b0, 1'b0, "R6 fill to shared ignored");
      cpu_op(1'b1, 7, 1'b0, "R6 still shared");
      dir_op(1, 7, 1'b1, 1'b0, 1'b0, "R6 fill ex ok");
      for (int k = 5; k < 8; k++) begin
         dir_op(k, 7, 1'b0, 1'b0, 1'b0, "R10 unknown kind");
         cpu_op(1'b1, 7, 1'b1, "R10 excl unchanged");
      end
      dir_op(7, 1, 1'b0, 1'b0, 1'b0, "R10 unknown on shared");
      cpu_op(1'b0, 1, 1'b1, "R10 shared unchanged");
   endtask

   task automatic t_conflict();
      // same line: directory invalidate wins, access not taken
      cpu_valid = 1'b1; cpu_store = 1'b0; cpu_idx = 3'd4;
      dir_valid = 1'b1; dir_kind = 3'd2; dir_idx = 3'd4;
      #1 chk(cpu_ready, 0, "R9 same-line not ready");
      @(negedge clk);
      chk(cpu_miss, 0, "R9 same-line no miss");
      chk(req_valid, 0, "R9 same-line no req");
      chk(rsp_valid, 1, "R9 same-line ack");
      dir_valid = 1'b0;
      #1 chk(cpu_ready, 1, "R9 ready after msg");
      // different lines: both proceed
      dir_valid = 1'b1; dir_kind = 3'd2; dir_idx = 3'd5;
      @(negedge clk);
      chk(cpu_miss, 1, "R9 diff-line miss");
      chk(req_idx, 4, "R9 diff-line req_idx");
      chk(rsp_valid, 1, "R9 diff-line ack");
      chk(rsp_idx, 5, "R9 diff-line rsp_idx");
      cpu_valid = 1'b0; dir_valid = 1'b0;
      dir_op(0, 4, 1'b1, 1'b0, 1'b0, "R9 finish fill");
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1'b1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_load_path();
      t_store_path();
      t_recall();
      t_invalidate();
      t_stale_and_unknown();
      t_conflict();
      repeat (2) @(negedge clk);
      finish_run();
   end

   initial begin
      repeat (20000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

endmodule